// File: doc/BRIEF.md
# Working-Register and Paged-Register Address Translator

This block turns the short register operands carried by an instruction into absolute 8-bit addresses for a 256-entry register file. An 8-bit address splits into two nibbles. The high nibble picks one of sixteen groups and the low nibble picks a register inside that group. The block holds two window pointers and a page pointer. It also tracks which of two working modes is active: one 16-register window, or two independent 8-register windows.

A pointer write comes in on one of four strobes, with an immediate byte. The strobe "set single window" selects single mode, "set window 0" and "set window 1" select twin mode, and "set page" loads the page pointer. An access gives either a 4-bit working-register number or a direct 8-bit address. The block returns the absolute address. It raises `top_sel` when that address falls in the paged top group, and `page_sel` then names the page to use. A direct address that points into the hidden group raises an error strobe and produces no address. The hidden group can only be reached through the working windows. The pointers read back through `rp0_rd`, `rp1_rd` and `page_rd`.

Top module: `regwin_xlate`

## Requirements
- R1: After reset, `rp0_rd`, `rp1_rd` and `page_rd` read 0x00, which means single mode with both windows and the page at zero.
- R2: Bits 1:0 of all three pointer readbacks always read 0, even after a write of 0xFF. The window group number sits in bits 7:3 and the page number in bits 7:2.
- R3: Bit 2 of both `rp0_rd` and `rp1_rd` shows one shared mode flag. `wr_single` clears it (single mode) and `wr_p0` or `wr_p1` sets it (twin mode). The latest write decides the mode, and the new value is visible one clock after the strobe.
- R4: In single mode, `wr_single` stores the requested group rounded down to an even group: writing 0x18 reads back 0x10. Working register n then maps to `{rp0_rd[7:4], n}`.
- R5: In twin mode, working registers 0 to 7 map to window-0 group*8 plus n. Registers 8 to 15 map to window-1 group*8 plus (n-8). For example, window 1 at 32 and register 12 give address 36.
- R6: A direct access outside group 0xD returns `dir_addr` unchanged, with `hidden_err` low.
- R7: A direct access to group 0xD (addresses 208 to 223) raises `hidden_err` and drives `abs_addr` to 0x00. A working-register access that lands in group 0xD is legal.
- R8: `top_sel` is high exactly when a legal access resolves into group 0xF (240 to 255). `page_sel` gives the page written by `wr_page` (immediate bits 7:2), and the page is unchanged when no page write occurs.
- R9: When `acc_en` is low, `abs_addr` is 0x00 and `hidden_err` and `top_sel` are low.
- R10: If several pointer strobes arrive in one cycle, `wr_single` wins over `wr_p0`/`wr_p1`. `wr_p0` and `wr_p1` together load both windows with the same group and select twin mode. `wr_page` is independent of the other strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_single | input | 1 | Set the single 16-register window from `wr_val` |
| wr_p0 | input | 1 | Set window 0 from `wr_val`, twin mode |
| wr_p1 | input | 1 | Set window 1 from `wr_val`, twin mode |
| wr_page | input | 1 | Set the page pointer from `wr_val` |
| wr_val | input | 8 | Immediate value for pointer writes |
| acc_en | input | 1 | An access is being translated this cycle |
| acc_work | input | 1 | 1: working-register operand, 0: direct address |
| work_num | input | 4 | Working-register number |
| dir_addr | input | 8 | Direct register address |
| abs_addr | output | 8 | Absolute register address |
| hidden_err | output | 1 | Illegal direct access to the hidden group |
| top_sel | output | 1 | Access falls in the paged top group |
| page_sel | output | PAGE_W | Selected page for top-group accesses |
| rp0_rd | output | 8 | Window-0 pointer readback |
| rp1_rd | output | 8 | Window-1 pointer readback |
| page_rd | output | 8 | Page pointer readback |

## Verification
The bench builds the block with its default parameters. These are a 6-bit page field, hidden group 0xD and paged group 0xF, so all 64 pages and both special groups lie at the real address boundaries. With these values the bench can place a working window directly over the hidden group and over the paged group. It can then compare those landings with direct accesses to the same addresses, and it can also exercise an odd single-mode request and simultaneous pointer strobes.

// File: rtl/regwin_xlate.sv
module regwin_xlate #(
  parameter int         PAGE_W     = 6,
  parameter logic [3:0] HIDDEN_GRP = 4'hD,
  parameter logic [3:0] PAGED_GRP  = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_single,
  input  logic              wr_p0,
  input  logic              wr_p1,
  input  logic              wr_page,
  input  logic [7:0]        wr_val,
  input  logic              acc_en,
  input  logic              acc_work,
  input  logic [3:0]        work_num,
  input  logic [7:0]        dir_addr,
  output logic [7:0]        abs_addr,
  output logic              hidden_err,
  output logic              top_sel,
  output logic [PAGE_W-1:0] page_sel,
  output logic [7:0]        rp0_rd,
  output logic [7:0]        rp1_rd,
  output logic [7:0]        page_rd
);
  localparam int PAD_W = 8 - PAGE_W;

  logic [4:0]        grp0, grp1;
  logic              twin;
  logic [PAGE_W-1:0] page;
  logic [7:0]        work_addr, raw_addr;
  logic              legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp0 <= '0;
      grp1 <= '0;
      twin <= 1'b0;
      page <= '0;
    end else begin
      if (wr_single) begin
        grp0 <= {wr_val[7:4], 1'b0};
        twin <= 1'b0;
      end else begin
        if (wr_p0) grp0 <= wr_val[7:3];
        if (wr_p1) grp1 <= wr_val[7:3];
        if (wr_p0 || wr_p1) twin <= 1'b1;
      end
      if (wr_page) page <= wr_val[7:PAD_W];
    end
  end

  always_comb begin
    if (!twin)            work_addr = {grp0[4:1], work_num};
    else if (work_num[3]) work_addr = {grp1, work_num[2:0]};
    else                  work_addr = {grp0, work_num[2:0]};
  end

  assign raw_addr   = acc_work ? work_addr : dir_addr;
  assign hidden_err = acc_en && !acc_work && (dir_addr[7:4] == HIDDEN_GRP);
  assign legal      = acc_en && !hidden_err;
  assign abs_addr   = legal ? raw_addr : 8'h00;
  assign top_sel    = legal && (raw_addr[7:4] == PAGED_GRP);
  assign page_sel   = page;
  assign rp0_rd     = {grp0, twin, 2'b00};
  assign rp1_rd     = {grp1, twin, 2'b00};
  assign page_rd    = {page, {PAD_W{1'b0}}};
endmodule

module regwin_xlate_chk #(
  parameter int         PAGE_W     = 6,
  parameter logic [3:0] HIDDEN_GRP = 4'hD,
  parameter logic [3:0] PAGED_GRP  = 4'hF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_single,
  input logic              wr_p0,
  input logic              wr_p1,
  input logic              wr_page,
  input logic              acc_en,
  input logic              acc_work,
  input logic [7:0]        dir_addr,
  input logic [7:0]        abs_addr,
  input logic              hidden_err,
  input logic              top_sel,
  input logic [PAGE_W-1:0] page_sel,
  input logic [7:0]        rp0_rd,
  input logic [7:0]        rp1_rd,
  input logic [7:0]        page_rd
);
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rp0_rd[1:0] == 2'b00) && (rp1_rd[1:0] == 2'b00) && (page_rd[1:0] == 2'b00)); // R2
  AST_MODE_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    rp0_rd[2] == rp1_rd[2]); // R3
  AST_SINGLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_single |=> (!rp0_rd[2] && !rp0_rd[3])); // R4
  AST_TWIN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_single && (wr_p0 || wr_p1)) |=> rp0_rd[2]); // R3
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_work && dir_addr[7:4] != HIDDEN_GRP) |-> (abs_addr == dir_addr && !hidden_err)); // R6
  AST_HIDDEN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_work && dir_addr[7:4] == HIDDEN_GRP) |-> (hidden_err && abs_addr == 8'h00)); // R7
  AST_TOP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    top_sel |-> (abs_addr[7:4] == PAGED_GRP && !hidden_err)); // R8
  AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_page |=> $stable(page_sel)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> (!hidden_err && !top_sel && abs_addr == 8'h00)); // R9
endmodule

bind regwin_xlate regwin_xlate_chk #(.PAGE_W(PAGE_W), .HIDDEN_GRP(HIDDEN_GRP), .PAGED_GRP(PAGED_GRP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_single(wr_single), .wr_p0(wr_p0), .wr_p1(wr_p1),
  .wr_page(wr_page), .acc_en(acc_en), .acc_work(acc_work), .dir_addr(dir_addr),
  .abs_addr(abs_addr), .hidden_err(hidden_err), .top_sel(top_sel), .page_sel(page_sel),
  .rp0_rd(rp0_rd), .rp1_rd(rp1_rd), .page_rd(page_rd)
);

// File: tb/sim_regwin_xlate.sv
`timescale 1ns/1ps
module sim_regwin_xlate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_single = 0, wr_p0 = 0, wr_p1 = 0, wr_page = 0;
  logic [7:0] wr_val = 0;
  logic       acc_en = 0, acc_work = 0;
  logic [3:0] work_num = 0;
  logic [7:0] dir_addr = 0;
  logic [7:0] abs_addr;
  logic       hidden_err, top_sel;
  logic [5:0] page_sel;
  logic [7:0] rp0_rd, rp1_rd, page_rd;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  regwin_xlate u0 (.*);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(bit s, bit a, bit b, bit p, logic [7:0] v);
    @(negedge clk);
    wr_single = s; wr_p0 = a; wr_p1 = b; wr_page = p; wr_val = v;
    @(posedge clk); #1;
    wr_single = 0; wr_p0 = 0; wr_p1 = 0; wr_page = 0;
  endtask

  task automatic acc(bit w, logic [3:0] n, logic [7:0] d);
    @(negedge clk);
    acc_en = 1; acc_work = w; work_num = n; dir_addr = d;
    #1;
  endtask

  task automatic t_reset;
    chk("R1 rp0", rp0_rd, 8'h00);
    chk("R1 rp1", rp1_rd, 8'h00);
    chk("R1 page", page_rd, 8'h00);
  endtask

  task automatic t_lowbits;
    wr(0, 1, 0, 0, 8'hFF);
    chk("R2 rp0", rp0_rd, 8'hFC);
    wr(0, 0, 1, 0, 8'hFF);
    chk("R2 rp1", rp1_rd, 8'hFC);
    wr(0, 0, 0, 1, 8'hFF);
    chk("R2 page", page_rd, 8'hFC);
  endtask

  task automatic t_mode;
    wr(1, 0, 0, 0, 8'h40);
    chk("R3 single rp0", rp0_rd, 8'h40);
    chk("R3 shared flag rp1", {7'b0, rp1_rd[2]}, 8'h00);
    wr(0, 0, 1, 0, 8'h28);
    chk("R3 twin rp0 flag", {7'b0, rp0_rd[2]}, 8'h01);
    chk("R3 twin rp1", rp1_rd, 8'h2C);
    wr(1, 0, 0, 0, 8'h40);
    chk("R3 last wins", {7'b0, rp1_rd[2]}, 8'h00);
  endtask

  task automatic t_single;
    wr(1, 0, 0, 0, 8'h18);
    chk("R4 even round", rp0_rd, 8'h10);
    acc(1, 4'd5, 8'h00);
    chk("R4 r5", abs_addr, 8'h15);
    acc(1, 4'd12, 8'h00);
    chk("R4 r12", abs_addr, 8'h1C);
    wr(1, 0, 0, 0, 8'h70);
    acc(1, 4'd7, 8'h00);
    chk("R4 r7 at 70", abs_addr, 8'h77);
    acc_en = 0;
  endtask

  task automatic t_twin;
    wr(0, 1, 0, 0, 8'd96);
    wr(0, 0, 1, 0, 8'd32);
    acc(1, 4'd5, 8'h00);
    chk("R5 r5", abs_addr, 8'd101);
    acc(1, 4'd12, 8'h00);
    chk("R5 r12", abs_addr, 8'd36);
    acc(1, 4'd8, 8'h00);
    chk("R5 r8", abs_addr, 8'd32);
    acc_en = 0;
  endtask

  task automatic t_direct;
    acc(0, 4'd0, 8'h42);
    chk("R6 pass", abs_addr, 8'h42);
    chk("R6 no err", {7'b0, hidden_err}, 8'h00);
    acc(0, 4'd0, 8'hD3);
    chk("R7 err", {7'b0, hidden_err}, 8'h01);
    chk("R7 addr", abs_addr, 8'h00);
    acc(0, 4'd0, 8'hCF);
    chk("R7 edge below", {7'b0, hidden_err}, 8'h00);
    acc_en = 0;
    wr(0, 1, 0, 0, 8'hD0);
    acc(1, 4'd3, 8'h00);
    chk("R7 working reach", abs_addr, 8'hD3);
    chk("R7 working no err", {7'b0, hidden_err}, 8'h00);
    acc_en = 0;
  endtask

  task automatic t_page;
    wr(0, 0, 0, 1, 8'h14);
    chk("R8 page sel", {2'b0, page_sel}, 8'h05);
    acc(0, 4'd0, 8'hF2);
    chk("R8 top sel", {7'b0, top_sel}, 8'h01);
    chk("R8 top addr", abs_addr, 8'hF2);
    acc(0, 4'd0, 8'hEF);
    chk("R8 not top", {7'b0, top_sel}, 8'h00);
    acc_en = 0;
    wr(0, 1, 0, 0, 8'hF8);
    chk("R8 page held", {2'b0, page_sel}, 8'h05);
    acc(1, 4'd2, 8'h00);
    chk("R8 working top", {7'b0, top_sel}, 8'h01);
    acc_en = 0;
  endtask

  task automatic t_idle;
    @(negedge clk);
    acc_en = 0; acc_work = 0; dir_addr = 8'hD5; #1;
    chk("R9 err idle", {7'b0, hidden_err}, 8'h00);
    chk("R9 addr idle", abs_addr, 8'h00);
    dir_addr = 8'hF1; #1;
    chk("R9 top idle", {7'b0, top_sel}, 8'h00);
  endtask

  task automatic t_priority;
    wr(0, 0, 1, 0, 8'h08);
    wr(1, 1, 0, 0, 8'h38);
    chk("R10 single wins", rp0_rd, 8'h30);
    chk("R10 rp1 kept", rp1_rd, 8'h08);
    wr(0, 1, 1, 1, 8'h88);
    chk("R10 both rp0", rp0_rd, 8'h8C);
    chk("R10 both rp1", rp1_rd, 8'h8C);
    chk("R10 page too", page_rd, 8'h88);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_lowbits();
    t_mode();
    t_single();
    t_twin();
    t_direct();
    t_page();
    t_idle();
    t_priority();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule